// File: doc/BRIEF.md
# Real-time clock event flags and interrupt enable

This block collects the event pulses of a real-time clock into a sticky status word and combines that word with an interrupt enable word to drive a single level interrupt. Each source has its own input: stopwatch expiry, alarm match, second, minute and hour rollover, 24-hour rollover, day alarm match and the completion of a synchronized control write. The counters and comparators that produce these pulses are outside the block. So is the write synchronizer; it only reports its busy state here, as a live input.

Software reads the status word to find out which events happened. It clears a flag by writing a one to its position, and it writes zeros wherever it wants to leave a flag alone. The enable word uses the same bit positions as the status word. An interrupt handler can therefore mask one word with the other directly. Flags latch whether or not their interrupt is enabled, so a polling driver sees every event.

Top module: `rtc_evt_irq`

## Requirements
- R1: While rst_n is low, and on the first cycle after it goes high, every latched status bit and every enable bit reads 0 and irq is 0.
- R2: Each event pulse sets one status bit, which reads 1 from the first clock edge that samples the pulse. The positions are: stopwatch bit 0, alarm bit 1, second bit 2, minute bit 3, hour bit 4, 24-hour bit 5, day alarm bit 6, write complete bit 15.
- R3: A status bit latches its event even when the matching enable bit is 0.
- R4: A status write with sts_we=1 clears, at the next edge, every latched bit written as 1 and leaves every bit written as 0 unchanged. Writing 0xFFFF clears all latched events.
- R5: If an event pulse and a write-one-to-clear of the same bit occur in the same cycle, the bit reads 1 afterwards.
- R6: Status bit 14 always equals the live wr_busy input, and status writes have no effect on it. Status bits 7 to 13 always read 0.
- R7: An enable write with en_we=1 loads bits 0 to 6 and bit 15 from en_wdata at the next edge. Enable bits 7 to 14 always read 0, and the enable word holds its value when en_we is 0.
- R8: irq is 1 exactly when some latched status bit and the enable bit at the same position are both 1, as held in the registers.
- R9: With no event pulse and sts_we=0, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_stopwatch | input | 1 | Stopwatch expiry pulse |
| ev_alarm | input | 1 | Alarm match pulse |
| ev_sec | input | 1 | Second rollover pulse |
| ev_min | input | 1 | Minute rollover pulse |
| ev_hour | input | 1 | Hour rollover pulse |
| ev_day | input | 1 | 24-hour rollover pulse |
| ev_day_alarm | input | 1 | Day alarm match pulse |
| ev_wr_done | input | 1 | Synchronized write completed pulse |
| wr_busy | input | 1 | Live write-in-progress level |
| sts_we | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | 16 | Status write data |
| en_we | input | 1 | Enable write strobe |
| en_wdata | input | 16 | Enable write data |
| sts_rdata | output | 16 | Status word read value |
| en_rdata | output | 16 | Enable word read value |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions take each write strobe and each event input to be a clean 0 or 1 at every sampled edge. They compare each edge against the one before it only after one full cycle out of reset, so pulses driven while reset is held do not count. The stimulus changes the inputs only at the falling clock edge and holds the inputs low during reset. Its random write data covers all sixteen bit positions, including the read-only and unused ones, while the event pulses, the strobes and wr_busy toggle freely.

// File: rtl/rtc_evt_irq.sv
module rtc_evt_irq #(
  parameter int W        = 16,
  parameter int BUSY_BIT = 14,
  parameter logic [W-1:0] KEEP = 16'h807F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_stopwatch,
  input  logic         ev_alarm,
  input  logic         ev_sec,
  input  logic         ev_min,
  input  logic         ev_hour,
  input  logic         ev_day,
  input  logic         ev_day_alarm,
  input  logic         ev_wr_done,
  input  logic         wr_busy,
  input  logic         sts_we,
  input  logic [W-1:0] sts_wdata,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] sts_rdata,
  output logic [W-1:0] en_rdata,
  output logic         irq
);
  logic [W-1:0] sts_q, en_q, set_v, clr_v;

  always_comb begin
    set_v     = '0;
    set_v[0]  = ev_stopwatch;
    set_v[1]  = ev_alarm;
    set_v[2]  = ev_sec;
    set_v[3]  = ev_min;
    set_v[4]  = ev_hour;
    set_v[5]  = ev_day;
    set_v[6]  = ev_day_alarm;
    set_v[15] = ev_wr_done;
  end

  assign clr_v = sts_we ? sts_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= ((sts_q & ~clr_v) | set_v) & KEEP;
      if (en_we) en_q <= en_wdata & KEEP;
    end
  end

  assign sts_rdata = sts_q | (W'(wr_busy) << BUSY_BIT);
  assign en_rdata  = en_q;
  assign irq       = |(sts_q & en_q);

  assert_set_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(set_v) & ~sts_q) == '0));

  assert_clear_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sts_we)) |-> ((sts_q & $past(sts_wdata & ~set_v)) == '0));

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sts_we) && ($past(set_v) == '0)) |-> $stable(sts_q));

  assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en_we)) |-> $stable(en_q));

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((sts_rdata & en_rdata) != '0));
endmodule

// File: tb/sim_rtc_evt_irq.sv
module sim_rtc_evt_irq;
  localparam logic [15:0] KEEP = 16'h807F;
  logic clk = 0, rst_n = 0;
  logic [15:0] ev = '0;
  logic wr_busy = 0, sts_we = 0, en_we = 0;
  logic [15:0] sts_wdata = '0, en_wdata = '0;
  logic [15:0] sts_rdata, en_rdata;
  logic irq;
  int checks = 0, fails = 0;
  logic [15:0] m_sts = '0, m_en = '0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_evt_irq u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_stopwatch(ev[0]), .ev_alarm(ev[1]), .ev_sec(ev[2]), .ev_min(ev[3]),
    .ev_hour(ev[4]), .ev_day(ev[5]), .ev_day_alarm(ev[6]), .ev_wr_done(ev[15]),
    .wr_busy(wr_busy), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .en_we(en_we), .en_wdata(en_wdata),
    .sts_rdata(sts_rdata), .en_rdata(en_rdata), .irq(irq));

  function automatic logic [15:0] exp_sts();
    return m_sts | ({15'd0, wr_busy} << 14);
  endfunction

  function automatic logic exp_irq();
    return |(m_sts & m_en);
  endfunction

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic check_all(input string r);
    chk({r, " status"}, sts_rdata, exp_sts());
    chk("R7 enable", en_rdata, m_en);
    chk("R8 irq", {15'd0, irq}, {15'd0, exp_irq()});
  endtask

  task automatic step(input logic [15:0] e, input logic swe, input logic [15:0] swd,
                      input logic ewe, input logic [15:0] ewd);
    ev = e; sts_we = swe; sts_wdata = swd; en_we = ewe; en_wdata = ewd;
    @(posedge clk);
    m_sts = ((m_sts & ~(swe ? swd : 16'h0)) | (e & KEEP)) & KEEP;
    if (ewe) m_en = ewd & KEEP;
    @(negedge clk);
    ev = '0; sts_we = 0; en_we = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset status", sts_rdata, 16'h0);
    chk("R1 reset irq", {15'd0, irq}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    // R2: each source to its own bit, R3: with enables off
    for (int i = 0; i < 16; i++) begin
      if (!KEEP[i]) continue;
      step(16'h1 << i, 0, 0, 0, 0);
      chk("R2 position", sts_rdata, exp_sts());
      chk("R3 latched with enable off", sts_rdata & (16'h1 << i), 16'h1 << i);
      chk("R8 irq off when masked", {15'd0, irq}, 16'h0);
    end
    // R4: 0xFFFF clears everything
    step(0, 1, 16'hFFFF, 0, 0);
    chk("R4 clear all", sts_rdata, 16'h0);
    // R6: bit 14 live, unaffected by writes; R9 hold
    wr_busy = 1; #1;
    chk("R6 busy live", sts_rdata, 16'h4000);
    step(0, 1, 16'h4000, 0, 0);
    chk("R6 busy write ignored", sts_rdata, 16'h4000);
    wr_busy = 0; #1;
    chk("R6 busy drops", sts_rdata, 16'h0);
    // R5: set wins over clear
    step(16'h0004, 0, 0, 0, 0);
    step(16'h0004, 1, 16'h0004, 0, 0);
    chk("R5 set wins", sts_rdata, 16'h0004);
    // R7 enables and R8 irq
    step(0, 0, 0, 1, 16'hFFFF);
    chk("R7 enable mask", en_rdata, 16'h807F);
    chk("R8 irq on", {15'd0, irq}, 16'h1);
    step(0, 1, 16'h0004, 0, 0);
    chk("R8 irq drops after clear", {15'd0, irq}, 16'h0);
    step(16'h8000, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R9 hold", sts_rdata, 16'h8000);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] e;
      e = $urandom() & $urandom() & KEEP;
      wr_busy = $urandom() % 2;
      step(e, ($urandom() % 3) == 0, $urandom(), ($urandom() % 5) == 0, $urandom());
      check_all("R4");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule